// File: doc/BRIEF.md
# Status Change Interrupt Line Controller

This block drives the active-low, open-drain attention line of a touch sensing front end. It watches two 8-bit status words, a detection word and an input word, and pulls the line low whenever either word differs from the value the host last collected. The host polls the status over a register bus. A read of either status address counts as collecting the status and releases the line, so the external pull-up can take it high.

If the status moves and then settles back to the value the host last collected before any read arrives, the line stays low. In that case a read of any register address releases it. A fixed number of clock ticks after reset is released, the line is also pulled low once, so the host learns that the device is ready. Any read releases this power-up assertion. The block drives only an enable for the pull-down. It never drives the line high.

Top module: `chg_irq_ctrl`

## Requirements
- R1: After reset `irq_pull_o` is 0. With both status words held at 0 and no reads, it stays 0 for the first POR_TICKS-1 rising edges after reset is released.
- R2: A change of `det_status_i` that is sampled at an edge with no read sets `irq_pull_o` to 1 after that edge.
- R3: A change of `in_status_i` that is sampled at an edge with no read sets `irq_pull_o` to 1 after that edge.
- R4: A read at address DET_ADDR (0) or IN_ADDR (1), with the status equal to its value in the previous cycle, clears `irq_pull_o` after that edge. The current status then becomes the reference for later changes.
- R5: While the status differs from the reference captured at the last clearing read, a read at any other address leaves `irq_pull_o` at 1.
- R6: If the status returns to the reference value before any read, `irq_pull_o` stays at 1. A read at any address then clears it.
- R7: If a status change is sampled at the same edge as a status read, `irq_pull_o` stays 1 after that edge.
- R8: `irq_pull_o` rises at exactly the POR_TICKS-th rising edge after reset is released. Any read clears this assertion while the status is unchanged.
- R9: Once set, `irq_pull_o` stays 1 through any number of cycles without a read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| det_status_i | input | 8 | Detection status word |
| in_status_i | input | 8 | Input status word |
| rd_en_i | input | 1 | Host register read strobe, one cycle per read |
| rd_addr_i | input | ADDR_W | Register address of the read |
| irq_pull_o | output | 1 | 1 = pull the line low, 0 = release it |

## Verification
The assertions assume that a read strobe lasts one cycle per read. They also assume that the status words are synchronous to `clk_i`, so that a change held for one edge is sampled at that edge. The bench drives every input at the falling edge, holds each read strobe for exactly one cycle and changes the status only between edges. It checks the output at the next falling edge, after the one register stage between input and line. The address sweep reads every address of a 4-bit map after a change, and the bit sweep toggles each status bit of both words one at a time.

// File: rtl/chg_irq_pkg.sv
package chg_irq_pkg;
  parameter int unsigned STAT_W = 8;

  typedef struct packed {
    logic [STAT_W-1:0] det;
    logic [STAT_W-1:0] inp;
  } status_t;
endpackage

// File: rtl/chg_irq_por_timer.sv
module chg_irq_por_timer #(
  parameter int unsigned POR_TICKS = 100_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic fire_o
);
  localparam int unsigned CntW = $clog2(POR_TICKS + 1);
  localparam logic [CntW-1:0] LastCnt = CntW'(POR_TICKS - 1);
  localparam logic [CntW-1:0] DoneCnt = CntW'(POR_TICKS);

  logic [CntW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (cnt_q != DoneCnt) cnt_q <= cnt_q + 1'b1;
  end

  // single pulse on the POR_TICKS-th edge after reset release
  assign fire_o = (cnt_q == LastCnt);
endmodule

// File: rtl/chg_irq_snapshot.sv
module chg_irq_snapshot
  import chg_irq_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  status_t cur_i,
  input  logic    capture_i,
  output logic    diff_o,   // status differs from reference
  output logic    moved_o   // status changed since previous cycle
);
  status_t ref_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= cur_i;
      if (capture_i) ref_q <= cur_i;
    end
  end

  assign diff_o  = (cur_i != ref_q);
  assign moved_o = (cur_i != prev_q);
endmodule

// File: rtl/chg_irq_flag.sv
module chg_irq_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rd_en_i,
  input  logic stat_rd_i,
  input  logic diff_i,
  input  logic moved_i,
  input  logic por_fire_i,
  output logic clear_o,
  output logic pend_o
);
  logic pend_q, pend_d;

  // status read always clears; other reads clear only when nothing is outstanding
  assign clear_o = rd_en_i && (stat_rd_i || !diff_i);

  always_comb begin
    pend_d = pend_q;
    if (clear_o) pend_d = moved_i;      // change racing the read survives
    else if (diff_i) pend_d = 1'b1;
    if (por_fire_i) pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= 1'b0;
    else pend_q <= pend_d;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/chg_irq_ctrl.sv
module chg_irq_ctrl
  import chg_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DET_ADDR  = 0,
  parameter int unsigned IN_ADDR   = 1,
  parameter int unsigned POR_TICKS = 100_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] det_status_i,
  input  logic [STAT_W-1:0] in_status_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              irq_pull_o
);
  localparam logic [ADDR_W-1:0] DetA = ADDR_W'(DET_ADDR);
  localparam logic [ADDR_W-1:0] InA  = ADDR_W'(IN_ADDR);

  status_t cur;
  logic stat_rd, diff, moved, por_fire, clear;

  assign cur.det = det_status_i;
  assign cur.inp = in_status_i;
  assign stat_rd = (rd_addr_i == DetA) || (rd_addr_i == InA);

  chg_irq_por_timer #(.POR_TICKS(POR_TICKS)) u_por (
    .clk_i (clk_i), .rst_ni(rst_ni), .fire_o(por_fire)
  );

  chg_irq_snapshot u_snap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cur_i    (cur),
    .capture_i(clear),
    .diff_o   (diff),
    .moved_o  (moved)
  );

  chg_irq_flag u_flag (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_en_i   (rd_en_i),
    .stat_rd_i (stat_rd),
    .diff_i    (diff),
    .moved_i   (moved),
    .por_fire_i(por_fire),
    .clear_o   (clear),
    .pend_o    (irq_pull_o)
  );
endmodule

// File: rtl/chg_irq_ctrl_chk.sv
module chg_irq_ctrl_chk #(
  parameter int unsigned ADDR_W   = 8,
  parameter int unsigned DET_ADDR = 0,
  parameter int unsigned IN_ADDR  = 1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [15:0]       stat_i,
  input logic              rd_en_i,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              por_fire_i,
  input logic              irq_pull_o
);
  logic [15:0] prev_q;
  logic        seen_q;
  logic        moved, stat_rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
      seen_q <= 1'b0;
    end else begin
      prev_q <= stat_i;
      seen_q <= 1'b1;
    end
  end

  assign moved   = seen_q && (stat_i != prev_q);
  assign stat_rd = rd_en_i && ((rd_addr_i == ADDR_W'(DET_ADDR)) || (rd_addr_i == ADDR_W'(IN_ADDR)));

  p_set_on_change_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (moved && !rd_en_i) |=> irq_pull_o);

  p_hold_no_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pull_o && !rd_en_i) |=> irq_pull_o);

  p_race_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && moved) |=> irq_pull_o);

  p_status_read_clears_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd && seen_q && !moved && !por_fire_i) |=> !irq_pull_o);

  p_por_sets_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_fire_i |=> irq_pull_o);
endmodule

bind chg_irq_ctrl chg_irq_ctrl_chk #(
  .ADDR_W(ADDR_W), .DET_ADDR(DET_ADDR), .IN_ADDR(IN_ADDR)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .stat_i    ({det_status_i, in_status_i}),
  .rd_en_i   (rd_en_i),
  .rd_addr_i (rd_addr_i),
  .por_fire_i(por_fire),
  .irq_pull_o(irq_pull_o)
);

// File: tb/chg_irq_ctrl_bench.sv
module chg_irq_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 4;
  localparam int POR = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [7:0] det = '0, inp = '0;
  logic rd_en = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic irq;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chg_irq_ctrl #(.ADDR_W(ADDR_W), .DET_ADDR(0), .IN_ADDR(1), .POR_TICKS(POR)) u_chg_irq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .det_status_i(det), .in_status_i(inp),
    .rd_en_i(rd_en), .rd_addr_i(rd_addr), .irq_pull_o(irq)
  );

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input logic exp, input string req);
    n_run++;
    if (irq !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_pull_o=%b expected %b", req, irq, exp);
    end
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    rd_en = 1'b1; rd_addr = a;
    step();
    rd_en = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 200_000);
    n_fail++;
    $display("FAIL watchdog: expected 0 got 1 timeout");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    check(1'b0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < POR - 1; i++) begin
      step(); check(1'b0, "R1");
    end
    step(); check(1'b1, "R8");
    for (int i = 0; i < 3; i++) begin step(); check(1'b1, "R9"); end
    rd(4'd7); check(1'b0, "R8");

    // per-bit sweep of the detection word
    for (int b = 0; b < 8; b++) begin
      det = 8'(1 << b);
      step(); check(1'b1, "R2");
      rd(4'd9); check(1'b1, "R5");
      rd(4'd0); check(1'b0, "R4");
    end
    // per-bit sweep of the input word
    for (int b = 0; b < 8; b++) begin
      inp = 8'(1 << b);
      step(); check(1'b1, "R3");
      rd(4'd3); check(1'b1, "R5");
      rd(4'd1); check(1'b0, "R4");
    end

    // change racing a status read
    rd_en = 1'b1; rd_addr = 4'd0; det = 8'h5A;
    step(); rd_en = 1'b0;
    check(1'b1, "R7");
    step(); check(1'b1, "R9");
    rd(4'd1); check(1'b0, "R4");

    // revert before read, for several non-status addresses
    for (int a = 2; a < 16; a += 3) begin
      det = 8'hC3;
      step(); check(1'b1, "R2");
      det = 8'h5A;
      step(); check(1'b1, "R6");
      rd(4'(a)); check(1'b0, "R6");
    end

    // exhaustive address sweep after a change
    for (int a = 0; a < 16; a++) begin
      inp = inp ^ 8'hFF;
      step(); check(1'b1, "R3");
      rd(4'(a)); check((a == 0 || a == 1) ? 1'b0 : 1'b1, (a < 2) ? "R4" : "R5");
      if (a > 1) begin rd(4'd0); check(1'b0, "R4"); end
    end

    // sticky for a long idle stretch
    det = 8'h01; inp = 8'h80;
    step();
    for (int i = 0; i < 10; i++) begin step(); check(1'b1, "R9"); end
    rd(4'd1); check(1'b0, "R4");

    // power-up pulse again after a second reset
    rst_n = 1'b0; det = '0; inp = '0;
    step(); check(1'b0, "R1");
    rst_n = 1'b1;
    for (int i = 0; i < POR - 1; i++) step();
    check(1'b0, "R1");
    step(); check(1'b1, "R8");
    rd(4'd0); check(1'b0, "R8");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    done = 1'b1;
    $finish;
  end
endmodule